// File: doc/BRIEF.md
# Phase-Offset PWM Generator with Step Injection

This block drives a PWM output from two counters that share one period. Both counters count base ticks, which arrive as single-cycle pulses on `adv_en` (in a typical build one system clock in eight). When the set-side counter wraps, the output register is set. When the clear-side counter wraps, the output register is cleared. The duty cycle is never held as a compare value. It exists only as the phase lead of the set-side counter over the clear-side one, measured in base ticks.

Two request inputs move that phase by one tick per request:

- A rising edge on `inc_i` gives the set-side counter one extra advance. This advance is placed in a clock cycle where no base tick falls.
- A rising edge on `dec_i` makes the set-side counter hold on its next base tick.

Each request is edge-detected and held pending until it is served. A request that would wrap the phase past either end is dropped.

The clear-side counter runs untouched, so the PWM period stays fixed. Reset places the set-side counter half a period ahead, which gives 50 % duty.

Top module: `pwm_phase_top`

## Requirements
- R1: The output rises only in the cycle after a set-side wrap and falls only in the cycle after a clear-side wrap. When both wraps happen in the same cycle, the clear wins, so a phase lead of 0 keeps the output low.
- R2: The clear-side counter advances by one in exactly the cycles where `adv_en` is high, and wraps from PERIOD-1 to 0. The PWM period is therefore PERIOD base ticks.
- R3: One served increment raises the steady-state high time by exactly one base tick.
- R4: One served decrement lowers the steady-state high time by exactly one base tick.
- R5: An increment is served only in a cycle with `adv_en` low, as one extra set-side advance. A decrement is served only in a cycle with `adv_en` high, by withholding that set-side advance. With no request pending, the set-side counter holds whenever `adv_en` is low.
- R6: A request is taken on the 0-to-1 transition of its input. One transition yields exactly one step, however long the input stays high.
- R7: An increment that arrives while the phase lead is PERIOD-1 is discarded. The lead never wraps to 0.
- R8: A decrement that arrives while the phase lead is 0 is discarded. The lead never wraps to PERIOD-1.
- R9: While `rst_n` is low, the output is low and the phase lead is PERIOD/2. The first period after reset is high for PERIOD/2 base ticks.
- R10: In steady state the output is high for exactly L base ticks of every PERIOD-tick cycle, where L is the current phase lead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Base tick enable, one-cycle pulses with gaps between them |
| inc_i | input | 1 | Duty increase request, taken on its rising edge |
| dec_i | input | 1 | Duty decrease request, taken on its rising edge |
| pwm_o | output | 1 | PWM output |

## Verification
The bench covers these corner cases and the failure each one would expose:

- **Saturation at both ends.** A design without saturation would wrap the duty from full to empty, or from empty to full. The final single increment after the extra decrements would then land on the wrong step.
- **Zero lead.** Here both wraps coincide. A design that lets the set win would produce a one-tick glitch on the output every period.
- **Held request input.** A design that is level-sensitive instead of edge-triggered would keep stepping for as long as the input is held.
- **Inject placement.** A design that merged an injected advance into a base tick would lose the step, and the per-clock comparison against the behavioural model would catch it in the cycle where the output edge lands.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    // Source of the set-side counter advance in a given cycle
    typedef enum logic [1:0] {
        ADV_HOLD   = 2'd0,
        ADV_BASE   = 2'd1,
        ADV_INJECT = 2'd2
    } adv_kind_e;

    typedef struct packed {
        logic pwm;
    } pwm_out_t;

    typedef struct packed {
        logic prev;
        logic pend;
    } req_state_t;

endpackage

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
    parameter int PERIOD = 256,
    parameter int INIT   = 0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  adv_i,
    output logic [((PERIOD > 2) ? $clog2(PERIOD) : 1)-1:0] cnt_o,
    output logic                                  wrap_o
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);
    localparam logic [W-1:0] START = W'(INIT);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = adv_i && (st_q.cnt == LAST);
        if (adv_i) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= START;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= LAST);  // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_o));  // R2

endmodule

// File: rtl/pwm_req_latch.sv
module pwm_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_i,
    output logic pend_o
);
    import pwm_phase_pkg::*;

    req_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d      = st_q;
        rise      = req_i && !st_q.prev;
        st_d.prev = req_i;
        // a fresh edge survives a same-cycle acknowledge
        st_d.pend = (st_q.pend && !ack_i) || rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    AST_ONE_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !rise) |=> !pend_o);  // R6

    AST_LEVEL_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prev && req_i && !st_q.pend) |=> !pend_o);  // R6

endmodule

// File: rtl/pwm_phase_top.sv
module pwm_phase_top #(
    parameter int PERIOD = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_en,
    input  logic inc_i,
    input  logic dec_i,
    output logic pwm_o
);
    import pwm_phase_pkg::*;

    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] K_MAX = W'(PERIOD - 1);
    localparam logic [W:0]   PER_X = (W + 1)'(PERIOD);
    localparam int           SET_INIT = PERIOD / 2;
    localparam int           N_REQ = 2;
    localparam int           IDX_INC = 0;
    localparam int           IDX_DEC = 1;

    logic [W-1:0]     clr_cnt, set_cnt, phase_k;
    logic             clr_wrap, set_wrap, set_adv;
    logic [N_REQ-1:0] req_in, req_pend, req_ack;
    adv_kind_e        sel;
    pwm_out_t         st_d, st_q;

    assign req_in[IDX_INC] = inc_i;
    assign req_in[IDX_DEC] = dec_i;

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        pwm_req_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_in[g]),
            .ack_i  (req_ack[g]),
            .pend_o (req_pend[g])
        );
    end

    pwm_phase_counter #(.PERIOD(PERIOD), .INIT(0)) u_clr_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv_en),
        .cnt_o  (clr_cnt),
        .wrap_o (clr_wrap)
    );

    pwm_phase_counter #(.PERIOD(PERIOD), .INIT(SET_INIT)) u_set_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (set_adv),
        .cnt_o  (set_cnt),
        .wrap_o (set_wrap)
    );

    // phase lead of set side over clear side, modulo PERIOD
    always_comb begin
        if (set_cnt >= clr_cnt) begin
            phase_k = set_cnt - clr_cnt;
        end else begin
            phase_k = W'({1'b0, set_cnt} + PER_X - {1'b0, clr_cnt});
        end
    end

    // advance selector: base tick, withheld tick, or extra tick in a gap
    always_comb begin
        req_ack          = '0;
        req_ack[IDX_DEC] = adv_en && req_pend[IDX_DEC];
        req_ack[IDX_INC] = !adv_en && req_pend[IDX_INC];
        if (adv_en) begin
            sel = (req_pend[IDX_DEC] && (phase_k != '0)) ? ADV_HOLD : ADV_BASE;
        end else begin
            sel = (req_pend[IDX_INC] && (phase_k != K_MAX)) ? ADV_INJECT : ADV_HOLD;
        end
        set_adv = (sel != ADV_HOLD);
    end

    always_comb begin
        st_d = st_q;
        if (clr_wrap) begin
            st_d.pwm = 1'b0;
        end else if (set_wrap) begin
            st_d.pwm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;

    AST_RISE_FROM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> $past(set_wrap));  // R1

    AST_FALL_FROM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_o) |-> $past(clr_wrap));  // R1

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wrap |=> !pwm_o);  // R1

    AST_SET_GAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_en && !req_pend[IDX_INC]) |=> $stable(set_cnt));  // R5

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_k == $past(phase_k) || phase_k == $past(phase_k) + 1'b1
                  || phase_k + 1'b1 == $past(phase_k)));  // R3

    AST_NO_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_k == K_MAX) |=> (phase_k != '0));  // R7

    AST_NO_BOTTOM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_k == '0) |=> (phase_k != K_MAX));  // R8

endmodule

// File: tb/test_pwm_phase_top.sv
module test_pwm_phase_top;
    localparam int CLK_PERIOD = 10;
    localparam int P = 16;
    localparam int DIV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv_en = 1'b0;
    logic inc_i = 1'b0;
    logic dec_i = 1'b0;
    logic pwm_o;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int m_c, m_k;
    bit m_pinc, m_pdec, m_prev_inc, m_prev_dec, m_pwm;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_phase_top #(.PERIOD(P)) i_pwm_phase_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (adv_en),
        .inc_i  (inc_i),
        .dec_i  (dec_i),
        .pwm_o  (pwm_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // base tick generator: one pulse every DIV clocks
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                adv_en = 1'b0;
                ph = 0;
            end else begin
                adv_en = (ph == DIV - 1);
                ph = (ph + 1) % DIV;
            end
        end
    end

    // cycle model: integers with modular phase, updated at each edge
    always @(posedge clk) begin
        int s;
        bit cw, sw, sadv;
        if (!rst_n) begin
            m_c = 0; m_k = P / 2; m_pinc = 0; m_pdec = 0;
            m_prev_inc = 0; m_prev_dec = 0; m_pwm = 0;
        end else begin
            s = (m_c + m_k) % P;
            cw = adv_en && (m_c == P - 1);
            sadv = adv_en;
            if (adv_en && m_pdec) begin
                if (m_k > 0) begin m_k--; sadv = 0; end
                m_pdec = 0;
            end
            if (!adv_en && m_pinc) begin
                if (m_k < P - 1) begin m_k++; sadv = 1; end
                m_pinc = 0;
            end
            sw = sadv && (s == P - 1);
            if (adv_en) m_c = (m_c + 1) % P;
            if (cw) m_pwm = 0;
            else if (sw) m_pwm = 1;
            if (inc_i && !m_prev_inc) m_pinc = 1;
            if (dec_i && !m_prev_dec) m_pdec = 1;
            m_prev_inc = inc_i;
            m_prev_dec = dec_i;
        end
    end

    always @(negedge clk) begin
        if (rst_n) chk(pwm_o === m_pwm, "R1 R5 per-cycle output", int'(pwm_o), int'(m_pwm));
    end

    task automatic pulse(input bit up);
        @(negedge clk);
        if (up) inc_i = 1'b1; else dec_i = 1'b1;
        @(negedge clk);
        inc_i = 1'b0;
        dec_i = 1'b0;
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic measure(output int hi, output int per);
        bit a;
        a = pwm_o;
        @(negedge clk);
        while (!(a && !pwm_o)) begin a = pwm_o; @(negedge clk); end
        hi = 0;
        per = 0;
        do begin
            per++;
            if (pwm_o) hi++;
            a = pwm_o;
            @(negedge clk);
        end while (!(a && !pwm_o));
    endtask

    task automatic check_duty(input int expk, input string tag, input bit settle);
        int hi, per;
        if (settle) repeat (P * DIV) @(negedge clk);
        measure(hi, per);
        chk(hi == expk * DIV, {tag, " high time R10"}, hi, expk * DIV);
        chk(per == P * DIV, {tag, " period R2"}, per, P * DIV);
    endtask

    task automatic check_low(input string tag);
        int hi;
        hi = 0;
        repeat (2 * P * DIV) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        chk(hi == 0, tag, hi, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(pwm_o == 1'b0, "R9 reset output low", int'(pwm_o), 0);
        rst_n = 1'b1;
        check_duty(P / 2, "R9 initial half duty", 1'b0);

        pulse(1'b1);
        check_duty(P / 2 + 1, "R3 one increment", 1'b1);
        pulse(1'b0);
        check_duty(P / 2, "R4 one decrement", 1'b1);

        @(negedge clk);
        inc_i = 1'b1;
        repeat (5 * DIV) @(negedge clk);
        inc_i = 1'b0;
        check_duty(P / 2 + 1, "R6 held request one step", 1'b1);

        for (int i = 0; i < P - 2 - P / 2; i++) pulse(1'b1);
        check_duty(P - 1, "R7 at maximum", 1'b1);
        pulse(1'b1);
        pulse(1'b1);
        check_duty(P - 1, "R7 increment ignored", 1'b1);

        for (int i = 0; i < P - 1; i++) pulse(1'b0);
        repeat (P * DIV) @(negedge clk);
        check_low("R1 R8 zero lead stays low");
        pulse(1'b0);
        pulse(1'b0);
        check_low("R8 decrement ignored at zero");
        pulse(1'b1);
        check_duty(1, "R8 R3 one step above zero", 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule